// File: doc/BRIEF.md
# System control register block

This block is a 4 KiB window of 32-bit registers on a simple single-cycle bus: an address, a write strobe, write data, and a combinational read data return. It collects the board-level odds and ends that firmware needs early in boot. These are a fixed identity word, the switch and boot-switch inputs, an LED output register, a card-presence input, a few plain storage words and four processor identity words. It also has two flag banks and two free-running time-base counters.

The two flag banks are written through a pair of addresses each. A write to the bank's own address ORs the written ones into the bank. A write to the companion address clears the bits that are set in the written mask. The general bank is cleared by either reset. The non-volatile bank survives the ordinary system reset and is cleared only by the power-on reset. Both counters are driven from the core clock through parameterized prescalers. The slow counter steps at 100 Hz by default and the fast one at 24 MHz. The configuration-transfer words at 0xA0 to 0xA8 belong to another block and read as zero here.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, led_out, both flag banks, both counters and all storage words are zero.
- R2: Offset 0x00 reads {REV[3:0], 2'b00, PLATFORM[9:0], VARIANT[3:0], PTYPE[3:0], BUILD[7:0]} from bit 31 down to bit 0, taken from parameters. Writes to it have no effect.
- R3: Offset 0x04 returns switch_in in bits 7:0 and zero above. A write to offset 0x08 loads wdata[7:0] into led_out, and reads of 0x08 return led_out in bits 7:0 and zero above.
- R4: Offset 0x5C is a counter that steps by one every CLK_HZ/FAST_HZ clocks. Offset 0x24 steps by one every CLK_HZ/SLOW_HZ clocks. Both are CNT_W bits wide, wrap modulo 2^CNT_W and are zero-extended on read.
- R5: A write to 0x30 ORs wdata into the general flags. A write to 0x34 clears each flag bit whose wdata bit is one. Reads of 0x30 return the flags, and reads of 0x34 return zero.
- R6: Offsets 0x38 and 0x3C act as the set and clear pair for the non-volatile flags. These flags are cleared only while por_n is low. The general flags, LEDs, counters and storage words are cleared while either rst_n or por_n is low.
- R7: Offset 0x48 returns card_present_in in bit 0 and zero above. Offset 0x58 returns boot_sw_in.
- R8: Offsets 0x4C, 0x60, 0x64, 0x84, 0x88, 0x8C and 0x90 are 32-bit read/write words. A write is visible on bus_rdata from the cycle after its clock edge.
- R9: Every other word offset in the window, including 0xA0 to 0xA8, reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert, synchronous release |
| por_n | input | 1 | Power-on reset, active low, also clears the non-volatile flags |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| switch_in | input | 8 | Switch inputs |
| boot_sw_in | input | 32 | Boot-select switch inputs |
| card_present_in | input | 1 | Card detect |
| led_out | output | 8 | LED drive |

## Verification
The assertions assume that both resets are released synchronously to clk. They also assume that bus_we, bus_addr and bus_wdata hold steady around each rising edge, so that one write hits exactly one word. The bench drives every bus signal and both resets only on falling edges. It samples one nanosecond after a falling edge and never overlaps a write with a reset pulse. Because the window decodes only one address per cycle, a set and a clear can never hit the same flag bank in one cycle, and the stimulus does not try to force that case.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  // Word indices (byte offset / 4) inside the 4 KiB window
  localparam int unsigned W_IDENT    = 32'h00;
  localparam int unsigned W_SWITCH   = 32'h01;
  localparam int unsigned W_LED      = 32'h02;
  localparam int unsigned W_CNT_SLOW = 32'h09;
  localparam int unsigned W_GF_SET   = 32'h0C;
  localparam int unsigned W_GF_CLR   = 32'h0D;
  localparam int unsigned W_NV_SET   = 32'h0E;
  localparam int unsigned W_NV_CLR   = 32'h0F;
  localparam int unsigned W_CARD     = 32'h12;
  localparam int unsigned W_BOOTSW   = 32'h16;
  localparam int unsigned W_CNT_FAST = 32'h17;

  localparam int unsigned NSTORE = 7;

  // Plain read/write words: flash control, misc, dma map, four processor ids
  function automatic int unsigned store_word(input int unsigned idx);
    case (idx)
      0:       return 32'h13;
      1:       return 32'h18;
      2:       return 32'h19;
      3:       return 32'h21;
      4:       return 32'h22;
      5:       return 32'h23;
      default: return 32'h24;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_tick_counter.sv
module sysctl_tick_counter #(
  parameter int unsigned DIV   = 4,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] value
);
  logic             tick;
  logic [CNT_W-1:0] value_d;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] presc_q;
      logic [PW-1:0] presc_d;
      logic          last;

      assign last    = (presc_q == PW'(DIV - 1));
      assign presc_d = last ? '0 : presc_q + 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
      end

      assign tick = last;
    end
  endgenerate

  assign value_d = value + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (tick) value <= value_d;
  end
endmodule

// File: rtl/sysctl_flag_bank.sv
module sysctl_flag_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] flags
);
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;
  logic [W-1:0] flags_d;

  always_comb begin
    set_bits = set_en ? mask : '0;
    clr_bits = clr_en ? mask : '0;
    flags_d  = (flags | set_bits) & ~clr_bits;  // clear takes priority
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flags <= '0;
    else if (set_en || clr_en) flags <= flags_d;
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned CLK_HZ   = 96_000_000,
  parameter int unsigned SLOW_HZ  = 100,
  parameter int unsigned FAST_HZ  = 24_000_000,
  parameter logic [3:0]  ID_REV   = 4'h2,
  parameter logic [9:0]  ID_PLAT  = 10'h020,
  parameter logic [3:0]  ID_VAR   = 4'h2,
  parameter logic [3:0]  ID_TYPE  = 4'h4,
  parameter logic [7:0]  ID_BUILD = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        switch_in,
  input  logic [31:0]       boot_sw_in,
  input  logic              card_present_in,
  output logic [7:0]        led_out
);
  import sysctl_pkg::*;

  localparam int unsigned WORD_W   = ADDR_W - 2;
  localparam int unsigned DIV_SLOW = CLK_HZ / SLOW_HZ;
  localparam int unsigned DIV_FAST = CLK_HZ / FAST_HZ;
  localparam logic [31:0] IDENT    = {ID_REV, 2'b00, ID_PLAT, ID_VAR, ID_TYPE, ID_BUILD};

  logic [WORD_W-1:0] word;
  int unsigned       word_idx;
  logic              rst_all;
  logic [CNT_W-1:0]  cnt_slow;
  logic [CNT_W-1:0]  cnt_fast;
  logic [31:0]       gen_flags;
  logic [31:0]       nv_flags;
  logic [31:0]       store_q [NSTORE];
  logic [7:0]        led_d;
  logic              led_en;

  assign word     = bus_addr[ADDR_W-1:2];
  assign word_idx = 32'(word);
  assign rst_all  = rst_n & por_n;

  sysctl_tick_counter #(.DIV(DIV_SLOW), .CNT_W(CNT_W)) u_cnt_slow (
    .clk(clk), .rst_n(rst_all), .value(cnt_slow));

  sysctl_tick_counter #(.DIV(DIV_FAST), .CNT_W(CNT_W)) u_cnt_fast (
    .clk(clk), .rst_n(rst_all), .value(cnt_fast));

  sysctl_flag_bank #(.W(32)) u_gen_flags (
    .clk(clk), .rst_n(rst_all),
    .set_en(bus_we && word_idx == W_GF_SET),
    .clr_en(bus_we && word_idx == W_GF_CLR),
    .mask(bus_wdata), .flags(gen_flags));

  sysctl_flag_bank #(.W(32)) u_nv_flags (
    .clk(clk), .rst_n(por_n),
    .set_en(bus_we && word_idx == W_NV_SET),
    .clr_en(bus_we && word_idx == W_NV_CLR),
    .mask(bus_wdata), .flags(nv_flags));

  // LED register
  always_comb begin
    led_en = bus_we && (word_idx == W_LED);
    led_d  = bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_all) begin
    if (!rst_all)    led_out <= '0;
    else if (led_en) led_out <= led_d;
  end

  // Plain storage words
  generate
    for (genvar i = 0; i < NSTORE; i++) begin : g_store
      logic st_en;
      assign st_en = bus_we && (word_idx == store_word(i));
      always_ff @(posedge clk or negedge rst_all) begin
        if (!rst_all)   store_q[i] <= '0;
        else if (st_en) store_q[i] <= bus_wdata;
      end
    end
  endgenerate

  // Read return
  always_comb begin
    bus_rdata = '0;
    case (word_idx)
      W_IDENT:    bus_rdata = IDENT;
      W_SWITCH:   bus_rdata[7:0] = switch_in;
      W_LED:      bus_rdata[7:0] = led_out;
      W_CNT_SLOW: bus_rdata[CNT_W-1:0] = cnt_slow;
      W_CNT_FAST: bus_rdata[CNT_W-1:0] = cnt_fast;
      W_GF_SET:   bus_rdata = gen_flags;
      W_NV_SET:   bus_rdata = nv_flags;
      W_CARD:     bus_rdata[0] = card_present_in;
      W_BOOTSW:   bus_rdata = boot_sw_in;
      default: begin
        for (int i = 0; i < NSTORE; i++) begin
          if (word_idx == store_word(i)) bus_rdata = store_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              rst_all,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [7:0]        led_out,
  input logic [31:0]       gen_flags,
  input logic [31:0]       nv_flags,
  input logic [CNT_W-1:0]  cnt_fast
);
  logic [ADDR_W-1:0] ba;
  logic hit_led, hit_gs, hit_gc, hit_ns, hit_nc;
  assign ba      = {bus_addr[ADDR_W-1:2], 2'b00};
  assign hit_led = bus_we && ba == ADDR_W'(12'h008);
  assign hit_gs  = bus_we && ba == ADDR_W'(12'h030);
  assign hit_gc  = bus_we && ba == ADDR_W'(12'h034);
  assign hit_ns  = bus_we && ba == ADDR_W'(12'h038);
  assign hit_nc  = bus_we && ba == ADDR_W'(12'h03C);

  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_all)
    !hit_led |=> $stable(led_out)); // R3

  AST_GF_SET: assert property (@(posedge clk) disable iff (!rst_all)
    hit_gs |=> ((gen_flags & $past(bus_wdata)) == $past(bus_wdata))); // R5

  AST_GF_CLR: assert property (@(posedge clk) disable iff (!rst_all)
    hit_gc |=> ((gen_flags & $past(bus_wdata)) == 32'h0)); // R5

  AST_GF_HOLD: assert property (@(posedge clk) disable iff (!rst_all)
    !(hit_gs || hit_gc) |=> $stable(gen_flags)); // R5

  AST_NV_KEEP: assert property (@(posedge clk) disable iff (!por_n)
    !(hit_ns || hit_nc) |=> $stable(nv_flags)); // R6

  AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_all)
    1'b1 |=> (cnt_fast == $past(cnt_fast) || cnt_fast == $past(cnt_fast) + 1'b1)); // R4
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned DIV_S = 24;
  localparam int unsigned DIV_F = 2;

  logic        clk;
  logic        rst_n;
  logic        por_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  switch_in;
  logic [31:0] boot_sw_in;
  logic        card_present_in;
  logic [7:0]  led_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sysctl_regs #(.ADDR_W(12), .CNT_W(CNT_W), .CLK_HZ(2400), .SLOW_HZ(100),
                .FAST_HZ(1200)) uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  function automatic bit mapped(input int w);
    case (w)
      0, 1, 2, 9, 12, 13, 14, 15, 18, 19, 22, 23, 24, 25, 33, 34, 35, 36: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d0, model;
    logic [11:0] st_addr [7];
    st_addr = '{12'h04C, 12'h060, 12'h064, 12'h084, 12'h088, 12'h08C, 12'h090};
    rst_n = 0; por_n = 0; bus_addr = '0; bus_we = 0; bus_wdata = '0;
    switch_in = '0; boot_sw_in = '0; card_present_in = 0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;

    // R1 reset state
    check("R1 led", {24'h0, led_out}, 32'h0);
    rd(12'h030, d); check("R1 gflags", d, 32'h0);
    rd(12'h038, d); check("R1 nvflags", d, 32'h0);
    for (int i = 0; i < 7; i++) begin
      rd(st_addr[i], d); check("R1 store", d, 32'h0);
    end

    // R2 identity
    rd(12'h000, d); check("R2 ident", d, 32'h2020_245A);
    wr(12'h000, 32'h0);
    rd(12'h000, d); check("R2 ident ro", d, 32'h2020_245A);

    // R3 switches and LEDs, full sweep
    for (int v = 0; v < 256; v++) begin
      switch_in = 8'(v);
      rd(12'h004, d); check("R3 switch", d, 32'(v));
    end
    for (int v = 0; v < 256; v++) begin
      wr(12'h008, {24'hA5C3E1, 8'(v)});
      rd(12'h008, d); check("R3 led read", d, 32'(v));
      check("R3 led pin", {24'h0, led_out}, 32'(v));
    end

    // R4 counters
    for (int k = 1; k <= 5; k++) begin
      rd(12'h05C, d0);
      repeat (DIV_F * k) @(posedge clk);
      rd(12'h05C, d); check("R4 fast rate", d, 32'(8'(d0 + k)));
    end
    rd(12'h05C, d0);
    repeat (DIV_F * 300) @(posedge clk);
    rd(12'h05C, d); check("R4 fast wrap", d, 32'(8'(d0 + 300)));
    rd(12'h024, d0);
    repeat (DIV_S * 3) @(posedge clk);
    rd(12'h024, d); check("R4 slow rate", d, 32'(8'(d0 + 3)));
    rd(12'h024, d0);
    repeat (DIV_S * 260) @(posedge clk);
    rd(12'h024, d); check("R4 slow wrap", d, 32'(8'(d0 + 260)));

    // R5 general flags
    model = '0;
    for (int i = 0; i < 16; i++) begin
      d0 = 32'h1 << (i * 2) | 32'(i * 32'h0101_0001);
      wr(12'h030, d0); model = model | d0;
      rd(12'h030, d); check("R5 set", d, model);
      d0 = 32'hF0F0_0000 >> i;
      wr(12'h034, d0); model = model & ~d0;
      rd(12'h030, d); check("R5 clear", d, model);
    end
    rd(12'h034, d); check("R5 clr reads zero", d, 32'h0);

    // R6 non-volatile flags versus resets
    wr(12'h038, 32'hA5A5_0001);
    wr(12'h03C, 32'h0000_0001);
    rd(12'h038, d); check("R6 nv set/clr", d, 32'hA5A5_0000);
    rd(12'h03C, d); check("R6 nv clr reads zero", d, 32'h0);
    wr(12'h030, 32'h0000_00FF);
    wr(12'h04C, 32'h1234_5678);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rd(12'h038, d); check("R6 nv kept", d, 32'hA5A5_0000);
    rd(12'h030, d); check("R6 gflags cleared", d, 32'h0);
    rd(12'h04C, d); check("R6 store cleared", d, 32'h0);
    check("R6 led cleared", {24'h0, led_out}, 32'h0);
    @(negedge clk); por_n = 0;
    repeat (2) @(negedge clk); por_n = 1;
    rd(12'h038, d); check("R6 nv por", d, 32'h0);

    // R7 inputs
    card_present_in = 1; rd(12'h048, d); check("R7 card 1", d, 32'h1);
    card_present_in = 0; rd(12'h048, d); check("R7 card 0", d, 32'h0);
    boot_sw_in = 32'h89AB_CDEF; rd(12'h058, d); check("R7 boot", d, 32'h89AB_CDEF);

    // R8 storage words
    for (int i = 0; i < 7; i++) wr(st_addr[i], 32'h0123_4567 ^ (32'(i) * 32'h1111_1111));
    for (int i = 0; i < 7; i++) begin
      rd(st_addr[i], d); check("R8 store", d, 32'h0123_4567 ^ (32'(i) * 32'h1111_1111));
    end
    wr(12'h008, 32'h0000_003C);
    wr(12'h030, 32'h0000_0F00);

    // R9 reserved window sweep
    for (int w = 0; w < 1024; w++) begin
      if (!mapped(w)) begin
        wr(12'(w * 4), 32'hFFFF_FFFF);
        rd(12'(w * 4), d); check("R9 reserved", d, 32'h0);
      end
    end
    for (int i = 0; i < 7; i++) begin
      rd(st_addr[i], d); check("R9 store intact", d, 32'h0123_4567 ^ (32'(i) * 32'h1111_1111));
    end
    rd(12'h030, d); check("R9 gflags intact", d, 32'h0000_0F00);
    rd(12'h038, d); check("R9 nv intact", d, 32'h0);
    check("R9 led intact", {24'h0, led_out}, 32'h3C);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule